// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Programmable Reset Delay

This block is the digital phase-frequency detector at the front of a clock-multiplying loop. It watches a reference clock and the divided feedback clock, samples both with a fast system clock, and finds their rising edges. A rising edge on the reference raises the `up_o` output and a rising edge on the feedback raises the `dn_o` output. When both outputs are high, a shared clear drops them again after a delay that is set at run time. The difference between the two pulse widths, counted in system cycles, equals the phase offset between the two inputs.

The clear delay sets a floor on the width of every pulse, so a downstream charge pump always sees both switches fully driven, even when the phase error is zero. A larger delay makes both switches conduct together for longer. That is why the delay is a register that can be rewritten while the loop runs. Edges that arrive while the clear is pending are dropped, which is how a classic three-state detector behaves.

Top module: `ovs_pfd`

## Requirements
- R1: While `rst_n` is low, and after its release, `up_o` and `dn_o` stay low until an input edge arrives. The delay setting returns to `DLY_INIT`, which is 3 by default.
- R2: A low-to-high change on `ref_i` makes `up_o` high after the third rising clock edge that follows the change: two synchroniser stages and one state flop. The output stays low after the second of those edges.
- R3: A low-to-high change on `fb_i` makes `dn_o` high with the same three-edge latency as in R2.
- R4: After both outputs have become high, they fall together on the same clock edge. That edge is D+1 edges after the one on which the second output rose, where D is the 4-bit unsigned delay setting.
- R5: At the limits of the setting, D=0 gives an overlap of exactly one cycle and D=15 gives an overlap of sixteen cycles.
- R6: A rising edge that reaches the state flops while both outputs are high is discarded, including one that arrives on the clearing edge itself. No pulse follows it.
- R7: A second rising edge on an input whose output is already high, while the other output is still low, does not lengthen or restart that pulse.
- R8: When `cfg_we` is high on a clock edge, `cfg_dly` is loaded as the new D. The new D applies from the next overlap onward. An overlap already under way keeps the D it started with.
- R9: If the reference leads by k cycles, the `up_o` width minus the `dn_o` width equals k. If it lags by k cycles, the `dn_o` width minus the `up_o` width equals k. If the inputs are aligned, the two widths are equal.
- R10: Only transitions count. An input that stays high after its pulse has been cleared does not set its output again.
- R11: A low `rst_n` sampled on a clock edge clears both outputs and the delay counter on that edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference clock, asynchronous to `clk` |
| fb_i | input | 1 | Divided feedback clock, asynchronous to `clk` |
| cfg_we | input | 1 | Write strobe for the clear-delay setting |
| cfg_dly | input | DLY_W | New clear-delay value D |
| up_o | output | 1 | Pulse asking the loop to speed up |
| dn_o | output | 1 | Pulse asking the loop to slow down |

## Verification
The bench sweeps signed phase offsets across the smallest, a middle and the largest delay setting. A detector that counted the delay wrongly would show pulse widths off by one or more, and one that cleared the two outputs on different edges would break the width difference. It also aims edges into the overlap window, including one that lands on the clearing edge. A design that latched those edges would produce a stray pulse after the clear. Further cases rewrite the delay in the middle of an overlap, repeat an edge on an input that is already high, and hold inputs high after a clear. These expose a counter that reloads live, a pulse that restarts, and a level-sensitive set. A reset in the middle of a pulse is also applied, to show that the outputs and the setting return to their reset values.

// File: rtl/ovs_pfd_pkg.sv
package ovs_pfd_pkg;
    // channel ordering used for the input and edge vectors
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/ovs_pfd_edge.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module ovs_pfd_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            st_d.chain = STAGES'({st_q.chain, sig_i});
            st_d.last  = st_q.chain[STAGES-1];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;

    // an edge strobe never lasts two cycles (feeds R2 and R3)
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ovs_pfd_core.sv
// UP/DOWN state flops and the delayed common clear.
module ovs_pfd_core #(
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise_i,
    input  logic             fb_rise_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             up_o,
    output logic             dn_o
);
    typedef struct packed {
        logic             up;
        logic             dn;
        logic [DLY_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     overlap;

    assign overlap = st_q.up & st_q.dn;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else if (overlap) begin
            // clear pending: new edges are dropped
            if (st_q.cnt == '0) begin
                st_d.up = 1'b0;
                st_d.dn = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else begin
            st_d.up = st_q.up | ref_rise_i;
            st_d.dn = st_q.dn | fb_rise_i;
            if (st_d.up && st_d.dn) begin
                st_d.cnt = dly_i;   // snapshot of the delay for this overlap
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;

    p_clear_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn) |=> (st_q.up == st_q.dn));

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn && st_q.cnt != '0) |=>
        (st_q.up && st_q.dn && st_q.cnt == DLY_W'($past(st_q.cnt) - 1'b1)));

    p_drop_at_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn && st_q.cnt == '0) |=> (!st_q.up && !st_q.dn));

    p_up_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.up) |-> $past(ref_rise_i));

    p_dn_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dn) |-> $past(fb_rise_i));

    p_load_on_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.up && st_q.dn) |-> (st_q.cnt == $past(dly_i)));

    p_sync_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!st_q.up && !st_q.dn && st_q.cnt == '0));
endmodule

// File: rtl/ovs_pfd.sv
// Oversampled phase-frequency detector, top level.
module ovs_pfd
    import ovs_pfd_pkg::*;
#(
    parameter int unsigned DLY_W       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DLY_INIT    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic             cfg_we,
    input  logic [DLY_W-1:0] cfg_dly,
    output logic             up_o,
    output logic             dn_o
);
    typedef struct packed {
        logic [DLY_W-1:0] dly;
    } cfg_st_t;

    cfg_st_t           cfg_d, cfg_q;
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] rise;

    assign raw_in[CH_REF] = ref_i;
    assign raw_in[CH_FB]  = fb_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ovs_pfd_edge #(
            .STAGES (SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    // delay configuration register
    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.dly = DLY_W'(DLY_INIT);
        end else if (cfg_we) begin
            cfg_d.dly = cfg_dly;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    ovs_pfd_core #(
        .DLY_W (DLY_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (rise[CH_REF]),
        .fb_rise_i  (rise[CH_FB]),
        .dly_i      (cfg_q.dly),
        .up_o       (up_o),
        .dn_o       (dn_o)
    );

    p_cfg_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q.dly == $past(cfg_dly)));

    p_cfg_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q.dly == DLY_W'(DLY_INIT)));
endmodule

// File: tb/ovs_pfd_tb.sv
`timescale 1ns/1ps
module ovs_pfd_tb;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_i = 1'b0;
    logic             fb_i = 1'b0;
    logic             cfg_we = 1'b0;
    logic [DLY_W-1:0] cfg_dly = '0;
    logic             up_o;
    logic             dn_o;

    always #4 clk = ~clk;   // 125 MHz

    ovs_pfd #(.DLY_W(DLY_W), .SYNC_STAGES(2), .DLY_INIT(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i),
        .cfg_we(cfg_we), .cfg_dly(cfg_dly), .up_o(up_o), .dn_o(dn_o)
    );

    typedef struct {
        int    up_w;
        int    dn_w;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    int   uw = 0;
    int   dw = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic nclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int u, int d, string tag);
        exp_t e;
        e.up_w = u; e.dn_w = d; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic set_dly(int d);
        cfg_we = 1'b1;
        cfg_dly = DLY_W'(d);
        nclk(1);
        cfg_we = 1'b0;
    endtask

    // drive one pulse pair, k>0: reference leads by k cycles
    task automatic pulse(int k, int d, string tag);
        int a;
        a = (k < 0) ? -k : k;
        push(d + 1 + ((k > 0) ? k : 0), d + 1 + ((k < 0) ? -k : 0), tag);
        if (k >= 0) begin
            ref_i = 1'b1; nclk(a); fb_i = 1'b1;
        end else begin
            fb_i = 1'b1; nclk(a); ref_i = 1'b1;
        end
        nclk(a + d + 8);
        // R10: inputs still high, outputs must have stayed cleared
        chk(!up_o && !dn_o, "R10", "outputs with inputs held high",
            int'(up_o) + int'(dn_o), 0);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);
    endtask

    // monitor: measure widths, compare against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (up_o) uw++;
            if (dn_o) dw++;
            if (!up_o && !dn_o && (uw > 0 || dw > 0)) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected pulse, up width", uw, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(uw == e.up_w, e.tag, "UP width", uw, e.up_w);
                    chk(dw == e.dn_w, e.tag, "DOWN width", dw, e.dn_w);
                    chk((uw - dw) == (e.up_w - e.dn_w), e.tag, "UP minus DOWN",
                        uw - dw, e.up_w - e.dn_w);
                end
                uw = 0;
                dw = 0;
            end
        end
    end

    initial begin
        int dl[3];
        int kl[5];
        dl = '{0, 5, 15};
        kl = '{-4, -1, 0, 2, 7};

        nclk(3);
        chk(!up_o && !dn_o, "R1", "outputs in reset", int'(up_o) + int'(dn_o), 0);
        rst_n = 1'b1;
        nclk(3);
        chk(!up_o && !dn_o, "R1", "outputs after reset", int'(up_o) + int'(dn_o), 0);

        // R1: default delay 3 after reset
        pulse(0, 3, "R1");

        // R2, R3: latency, reference leads by 3
        set_dly(2);
        push(6, 3, "R2");
        ref_i = 1'b1;
        nclk(2);
        chk(!up_o, "R2", "up before third edge", int'(up_o), 0);
        nclk(1);
        chk(up_o, "R2", "up after third edge", int'(up_o), 1);
        chk(!dn_o, "R3", "dn without feedback edge", int'(dn_o), 0);
        fb_i = 1'b1;
        nclk(2);
        chk(!dn_o, "R3", "dn before third edge", int'(dn_o), 0);
        nclk(1);
        chk(dn_o, "R3", "dn after third edge", int'(dn_o), 1);
        nclk(10);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);

        // R6: feedback edge inside the overlap, D=6
        set_dly(6);
        push(7, 7, "R6");
        ref_i = 1'b1; fb_i = 1'b1;
        nclk(1); fb_i = 1'b0;
        nclk(1); fb_i = 1'b1;
        nclk(20);
        chk(!up_o && !dn_o, "R6", "no pulse after mid-overlap edge",
            int'(up_o) + int'(dn_o), 0);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);

        // R6: feedback edge on the clearing edge, D=1
        set_dly(1);
        push(2, 2, "R6");
        ref_i = 1'b1; fb_i = 1'b1;
        nclk(1); fb_i = 1'b0;
        nclk(1); fb_i = 1'b1;
        nclk(20);
        chk(!up_o && !dn_o, "R6", "no pulse after clearing-edge hit",
            int'(up_o) + int'(dn_o), 0);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);

        // R7: repeated reference edge while up alone is high
        set_dly(2);
        push(9, 3, "R7");
        ref_i = 1'b1;
        nclk(1); ref_i = 1'b0;
        nclk(2); ref_i = 1'b1;
        nclk(3); fb_i = 1'b1;
        nclk(20);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);

        // R8: delay rewritten during an overlap
        set_dly(9);
        push(10, 10, "R8");
        ref_i = 1'b1; fb_i = 1'b1;
        nclk(5);
        set_dly(2);
        nclk(20);
        ref_i = 1'b0; fb_i = 1'b0;
        nclk(4);
        pulse(0, 2, "R8");

        // R9 sweep, with R4 and R5 at the limits of the setting
        for (int i = 0; i < 3; i++) begin
            set_dly(dl[i]);
            for (int j = 0; j < 5; j++) begin
                pulse(kl[j], dl[i], (dl[i] == 5) ? "R9 R4" : "R9 R5");
            end
        end

        // R11: reset in the middle of an up pulse
        push(2, 0, "R11");
        ref_i = 1'b1;
        nclk(4);
        rst_n = 1'b0;
        ref_i = 1'b0;
        nclk(1);
        chk(!up_o, "R11", "up after reset edge", int'(up_o), 0);
        nclk(2);
        rst_n = 1'b1;
        nclk(8);
        chk(!up_o && !dn_o, "R11", "outputs after reset release",
            int'(up_o) + int'(dn_o), 0);
        // R1: setting back to its reset value
        pulse(0, 3, "R1");

        nclk(5);
        chk(sb_q.size() == 0, "R4", "expected pulses never seen", sb_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule